// File: doc/BRIEF.md
# HDLC Transmit Zero-Bit Inserter

This block is the bit-serial transparency stage at the end of a bit-oriented frame transmitter. The framing logic offers one bit at a time on a ready/valid input. A qualifier marks the bits that belong to an opening or closing flag. Each pulse of the bit-clock enable moves exactly one bit onto the line. Outside flags, a run of consecutive ones is counted. Once the run reaches the configured length (five by default), the next bit time carries an extra zero. During that bit time the input is held off, so no offered bit is lost.

Flag bits go to the line unmodified and never trigger insertion, so the six-ones flag pattern survives. The same path carries every non-flag bit, including the frame check sequence bits that the CRC generator feeds back in. A separate tap presents each accepted non-flag bit as it was before insertion, so the CRC generator never sees an inserted zero. When nothing is offered, the line idles at a fixed level.

Top module: `hdlc_zero_inserter`

## Requirements
- R1: Once RUN_LEN (default 5) consecutive non-flag ones have been sent, the next bit time emits a single 0 on `line_bit`, whatever the input offers.
- R2: Non-flag bits, whether address, control, payload or check-sequence bits, appear on the line unchanged and in order, with inserted zeros as the only additions.
- R3: Bits accepted with `in_flag`=1 appear on the line unchanged, and a run of six ones inside a flag causes no insertion.
- R4: Emitting a flag bit resets the run count of ones to zero.
- R5: Emitting a 0, whether it is a data zero or an inserted zero, resets the run count to zero.
- R6: `in_ready` is 0 for exactly the one bit time in which an inserted zero is emitted, and is 1 at all other times. A bit is accepted only on a `bit_en` cycle with `in_valid` and `in_ready` both 1.
- R7: For each accepted non-flag bit, `crc_tap_valid` pulses for one cycle together with the line update, and `crc_tap_bit` equals that bit. Flag bits and inserted zeros never raise `crc_tap_valid`.
- R8: Each `bit_en` pulse produces exactly one line bit, and `line_strobe` is 1 in the cycle after the pulse. Between pulses, `line_bit` holds its value and `line_strobe` is 0.
- R9: On a bit time with no valid input and no pending insertion, the line carries IDLE_LEVEL (default 1) and the run count is reset.
- R10: After reset, `line_bit`=IDLE_LEVEL, `line_strobe`=0, `crc_tap_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle pulse per line bit time |
| in_valid | input | 1 | Upstream offers a bit |
| in_bit | input | 1 | Offered bit value |
| in_flag | input | 1 | Offered bit belongs to a flag |
| in_ready | output | 1 | Block accepts a bit on this bit time |
| line_bit | output | 1 | Line bit, held between bit times |
| line_strobe | output | 1 | Pulse marking a new line bit |
| crc_tap_valid | output | 1 | Pulse: accepted non-flag bit for the CRC |
| crc_tap_bit | output | 1 | Pre-insertion bit value for the CRC |

## Verification
Two things can fall on the same bit time: the fifth one of a run, which arms an insertion, and a flag qualifier or a zero offered in the next bit. The next bit is also where the stall and the inserted zero compete with the offered input. The bench provokes these collisions with directed runs: five ones followed by a flag, a flag containing six ones, and ones that straddle an inserted zero. Long random streams weighted toward ones add to these. Each bit time is judged against a bench model of the run count, which predicts `in_ready` before the pulse and predicts the line and tap values one cycle after it.

// File: rtl/hdlc_zi_pkg.sv
package hdlc_zi_pkg;

   typedef enum logic [1:0] {
      EMIT_IDLE  = 2'd0,
      EMIT_STUFF = 2'd1,
      EMIT_FLAG  = 2'd2,
      EMIT_DATA  = 2'd3
   } emit_kind_e;

   // value placed on the line for a given kind of bit time
   function automatic logic emit_value(emit_kind_e kind, logic data, logic idle_lvl);
      logic v;
      case (kind)
         EMIT_STUFF: v = 1'b0;
         EMIT_FLAG:  v = data;
         EMIT_DATA:  v = data;
         default:    v = idle_lvl;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/zi_ones_counter.sv
module zi_ones_counter
   import hdlc_zi_pkg::*;
#(
   parameter int RUN_LEN = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  emit_kind_e kind,
   input  logic       data,
   output logic       stuff_due
);
   localparam int CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

   generate
      if (RUN_LEN < 2) begin : g_bad_len
         $error("zi_ones_counter: RUN_LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] run_q, run_d;

   always_comb begin
      run_d = run_q;
      if (step) begin
         if (kind == EMIT_DATA && data) run_d = run_q + CW'(1);
         else                           run_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= run_d;
   end

   assign stuff_due = (run_q == FULL);

endmodule

// File: rtl/zi_line_reg.sv
module zi_line_reg #(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic value,
   output logic line_bit,
   output logic line_strobe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_bit    <= IDLE_LEVEL;
         line_strobe <= 1'b0;
      end else begin
         line_strobe <= step;
         if (step) line_bit <= value;
      end
   end
endmodule

// File: rtl/zi_crc_tap.sv
module zi_crc_tap #(
   parameter bit TAP_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic data,
   output logic tap_valid,
   output logic tap_bit
);
   generate
      if (TAP_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tap_valid <= 1'b0;
               tap_bit   <= 1'b0;
            end else begin
               tap_valid <= take;
               if (take) tap_bit <= data;
            end
         end
      end else begin : g_comb
         // unused in comb variant
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tap_valid  = take;
         assign tap_bit    = data;
      end
   endgenerate
endmodule

// File: rtl/hdlc_zero_inserter.sv
module hdlc_zero_inserter
   import hdlc_zi_pkg::*;
#(
   parameter int   RUN_LEN    = 5,
   parameter logic IDLE_LEVEL = 1'b1,
   parameter bit   TAP_REG    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic in_valid,
   input  logic in_bit,
   input  logic in_flag,
   output logic in_ready,
   output logic line_bit,
   output logic line_strobe,
   output logic crc_tap_valid,
   output logic crc_tap_bit
);
   logic       stuff_due;
   logic       take;
   emit_kind_e kind;
   logic       value;

   // a pending insertion wins over any offered bit
   always_comb begin
      if (stuff_due)     kind = EMIT_STUFF;
      else if (in_valid) kind = in_flag ? EMIT_FLAG : EMIT_DATA;
      else               kind = EMIT_IDLE;
   end

   assign in_ready = ~stuff_due;
   assign take     = bit_en & in_valid & in_ready;
   assign value    = emit_value(kind, in_bit, IDLE_LEVEL);

   zi_ones_counter #(.RUN_LEN(RUN_LEN)) u_count (
      .clk(clk), .rst_n(rst_n), .step(bit_en), .kind(kind),
      .data(in_bit), .stuff_due(stuff_due));

   zi_line_reg #(.IDLE_LEVEL(IDLE_LEVEL)) u_line (
      .clk(clk), .rst_n(rst_n), .step(bit_en), .value(value),
      .line_bit(line_bit), .line_strobe(line_strobe));

   zi_crc_tap #(.TAP_REG(TAP_REG)) u_tap (
      .clk(clk), .rst_n(rst_n), .take(take & ~in_flag), .data(in_bit),
      .tap_valid(crc_tap_valid), .tap_bit(crc_tap_bit));

endmodule

// File: rtl/hdlc_zi_checker.sv
module hdlc_zi_checker #(
   parameter bit TAP_REG = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic in_valid,
   input logic in_bit,
   input logic in_flag,
   input logic in_ready,
   input logic line_bit,
   input logic line_strobe,
   input logic crc_tap_valid,
   input logic crc_tap_bit
);
   assert_stuff_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !in_ready |=> !line_bit);

   assert_ready_one_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !in_ready |=> in_ready);

   assert_flag_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && in_valid && in_ready && in_flag |=> line_bit == $past(in_bit));

   assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> !line_strobe && $stable(line_bit));

   generate
      if (TAP_REG) begin : g_tap
         assert_tap_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
            crc_tap_valid |-> line_strobe && line_bit == crc_tap_bit);
         assert_tap_no_stuff_R7: assert property (@(posedge clk) disable iff (!rst_n)
            bit_en && !in_ready |=> !crc_tap_valid);
      end
   endgenerate
endmodule

bind hdlc_zero_inserter hdlc_zi_checker #(.TAP_REG(TAP_REG)) chk_i (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
   .in_bit(in_bit), .in_flag(in_flag), .in_ready(in_ready),
   .line_bit(line_bit), .line_strobe(line_strobe),
   .crc_tap_valid(crc_tap_valid), .crc_tap_bit(crc_tap_bit));

// File: tb/hdlc_zero_inserter_tb.sv
module hdlc_zero_inserter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RUN_LEN    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, in_valid = 1'b0, in_bit = 1'b0, in_flag = 1'b0;
   logic in_ready, line_bit, line_strobe, crc_tap_valid, crc_tap_bit;

   int tests = 0;
   int fails = 0;
   int mrun  = 0;     // model run count of ones
   logic mline = 1'b1;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_zero_inserter dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
      .in_bit(in_bit), .in_flag(in_flag), .in_ready(in_ready),
      .line_bit(line_bit), .line_strobe(line_strobe),
      .crc_tap_valid(crc_tap_valid), .crc_tap_bit(crc_tap_bit));

   task automatic check(string req, logic act, logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit stuff_due_model();
      return mrun == RUN_LEN;
   endfunction

   // one bit time: offer (v,b,f), pulse bit_en, check results, then gap cycles
   task automatic step(logic v, logic b, logic f, int gap, string tag);
      logic exp_line, exp_tap;
      bit   pend;
      @(negedge clk);
      in_valid = v; in_bit = b; in_flag = f; bit_en = 1'b1;
      #1;
      pend = stuff_due_model();
      check({tag, " R6 ready"}, in_ready, !pend);
      if (pend) begin
         exp_line = 1'b0; exp_tap = 1'b0; mrun = 0;                  // R1 R5
      end else if (v && f) begin
         exp_line = b; exp_tap = 1'b0; mrun = 0;                     // R3 R4
      end else if (v) begin
         exp_line = b; exp_tap = 1'b1; mrun = b ? mrun + 1 : 0;      // R2 R5
      end else begin
         exp_line = 1'b1; exp_tap = 1'b0; mrun = 0;                  // R9
      end
      @(negedge clk);
      bit_en = 1'b0;
      check({tag, " R8 strobe"}, line_strobe, 1'b1);
      check({tag, " R2 line"}, line_bit, exp_line);
      check({tag, " R7 tap valid"}, crc_tap_valid, exp_tap);
      if (exp_tap) check({tag, " R7 tap bit"}, crc_tap_bit, b);
      mline = exp_line;
      for (int i = 0; i < gap; i++) begin
         @(negedge clk);
         check({tag, " R8 hold"}, line_bit, mline);
         check({tag, " R8 no strobe"}, line_strobe, 1'b0);
      end
   endtask

   task automatic send_bits(logic [15:0] pat, int n, logic f, string tag);
      for (int i = n - 1; i >= 0; i--) begin
         // a stall slot does not consume: repeat the same bit
         while (stuff_due_model()) step(1'b1, pat[i], f, 0, tag);
         step(1'b1, pat[i], f, 0, tag);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      int seed;
      seed = 32'h5eed_0b17;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R10 ready", in_ready, 1'b1);
      check("R10 line", line_bit, 1'b1);
      check("R10 strobe", line_strobe, 1'b0);
      check("R10 tap", crc_tap_valid, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: six data ones -> zero after the fifth
      send_bits(16'b111111, 6, 1'b0, "R1 six ones");
      // R3: flag with six ones, no insertion
      send_bits(16'b01111110, 8, 1'b1, "R3 flag");
      // R4: four ones, flag bit, four ones: no insertion
      send_bits(16'b1111, 4, 1'b0, "R4 pre");
      send_bits(16'b0, 1, 1'b1, "R4 flag0");
      step(1'b1, 1'b1, 1'b1, 0, "R4 flag1");
      send_bits(16'b1111, 4, 1'b0, "R4 post");
      // R5: five ones, inserted zero, four ones: one insertion only
      send_bits(16'b1111111110, 10, 1'b0, "R5 straddle");
      // R1/R3 collision: five ones then flag offered during stall
      send_bits(16'b11111, 5, 1'b0, "R1 arm");
      send_bits(16'b01111110, 8, 1'b1, "R3 after stall");
      // R9: ones, idle, ones -> idle clears count
      send_bits(16'b111, 3, 1'b0, "R9 pre");
      step(1'b0, 1'b0, 1'b0, 2, "R9 idle");
      send_bits(16'b1111, 4, 1'b0, "R9 post");

      // random stream weighted toward ones
      for (int k = 0; k < 4000; k++) begin
         logic v, b, f;
         v = ($urandom % 8) != 0;
         b = ($urandom % 4) != 0;
         f = ($urandom % 10) == 0;
         step(v, b, f, $urandom % 3, "rand");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule